// File: doc/BRIEF.md
# Multi-channel down-counting timer

This block is a memory-mapped timer with a parameterised number of independent down-counters, two by default. Each channel has a control word, an interval value that acts as the reload value, and a current count that software can read. A channel counts down on ticks taken from one of several tick-enable inputs, divided by a power of two from 1 to 128. It runs either periodically, reloading from its interval each time it passes zero, or as a one-shot that stops and clears its own enable. Software that wants a rising timestamp inverts the count it reads.

All channels share one interrupt-enable register and one interrupt-status register, and together they drive a single interrupt line. A status bit sets whenever its channel expires and is cleared by writing 1 to it. A change to a channel's control word does not act at once. The new enable state, and any load from the interval, take effect only on the second tick of the newly selected source, which models the settling time of a slower timer clock domain. Software therefore waits a few ticks of a free-running channel after any enable change.

Top module: `mtimer_periph`

## Requirements
- R1: Register map. The interrupt enable is at 0x00, with bit n belonging to channel n. The interrupt status is at 0x04. Channel n has its control word at 0x10*n+0x10, its interval at 0x10*n+0x14 and its current count at 0x10*n+0x18. `bus_rdata_o` returns the register addressed one clock edge earlier. Every other address reads as zero, and so do the enable and status bits above the channel count.
- R2: Control word layout. Bit 0 is enable, bit 1 is load-from-interval, bits 3:2 pick the index of the `tick_src_i` bit that drives the channel, bits 6:4 hold the prescale exponent, and bit 7 selects one-shot mode (0 means periodic). Written bits above bit 7 are dropped and read back as zero.
- R3: A control write leaves the channel's running state untouched until the second rising tick of the selected source that follows the write. Only at that settle point does the channel adopt the written enable bit. Another control write restarts the wait.
- R4: If the load bit is set at the settle point, the count takes the interval value and the load bit reads back 0 from then on.
- R5: A running channel decrements once for every 2^p ticks of its source, where p is bits 6:4. A stopped channel holds its count.
- R6: In periodic mode, a counting tick that finds the count at 0 reloads the interval value and sets the channel's status bit.
- R7: In one-shot mode, a counting tick that finds the count at 0 sets the status bit, stops the channel, leaves the count at 0 and clears the enable bit in the control word.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged. An expiry in the same cycle wins over the clear, and status sets whatever the interrupt-enable bit says.
- R9: `irq_o` is high exactly one cycle after some channel has both its status bit and its interrupt-enable bit set.
- R10: A periodic channel whose interval is 0xFFFFFFFF continues from 0 to 0xFFFFFFFF and keeps counting over the full range.
- R11: After reset, every register, `bus_rdata_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and timer clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_src_i | input | NUM_SRC | Per-source tick enables, each one cycle wide |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | CNT_W | Write data |
| bus_rdata_o | output | CNT_W | Registered read data |
| irq_o | output | 1 | Combined, registered interrupt request |

## Verification
The assertions check on every cycle the local rules of each channel. A counting tick decrements the count by exactly one, a stopped channel holds its count, expiry reloads the count in periodic mode and stops the channel in one-shot mode, a load at the settle point copies the interval, and nothing changes the running state in the cycle after a control write. At the shared registers they check that expiries set status, that write-1-to-clear works and that the interrupt stays low without an enabled pending bit. The bench's scenarios alone can show the settle point that waits for a second tick of a particular source, the effective rate of the prescaler, the self-clearing enable of a one-shot, the wrap from 0 to the full-range interval, and read data compared on every clock against a behavioural model while several sources run together.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  // Control word, bit 7 down to bit 0
  typedef struct packed {
    logic       oneshot;  // 1: stop at expiry, 0: periodic
    logic [2:0] psc;      // prescale exponent
    logic [1:0] src;      // tick source index
    logic       load;     // load interval at settle point
    logic       en;       // run request
  } chan_ctrl_t;

  localparam int CTRL_W  = $bits(chan_ctrl_t);
  localparam int SEL_W   = 2;
  localparam int PSC_W   = 3;

  // Word offsets inside a 16-byte register block
  localparam logic [3:0] W_SHARED_IEN = 4'h0;
  localparam logic [3:0] W_SHARED_IST = 4'h4;
  localparam logic [3:0] W_CH_CTRL    = 4'h0;
  localparam logic [3:0] W_CH_IVAL    = 4'h4;
  localparam logic [3:0] W_CH_CNT     = 4'h8;

endpackage

// File: rtl/mtimer_tick_sel.sv
module mtimer_tick_sel #(
  parameter int NUM_SRC = 4,
  parameter int SEL_W   = 2,
  parameter int PSC_W   = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [PSC_W-1:0]   psc_i,
  input  logic               clear_i,
  input  logic               run_i,
  output logic               src_tick_o,
  output logic               scaled_tick_o
);

  localparam int PRE_W = (1 << PSC_W) - 1;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    src_tick_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel_i == SEL_W'(i)) src_tick_o = src_i[i];
    end
    // 2^p - 1; p at its maximum wraps to all ones
    mask          = (PRE_W'(1) << psc_i) - PRE_W'(1);
    scaled_tick_o = src_tick_o && ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || clear_i) pre_q <= '0;
    else if (run_i && src_tick_o) pre_q <= pre_q + 1'b1;
  end

endmodule

// File: rtl/mtimer_chan.sv
module mtimer_chan
  import mtimer_pkg::*;
#(
  parameter int NUM_SRC    = 4,
  parameter int CNT_W      = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               ctrl_we_i,
  input  logic               ival_we_i,
  input  logic [CNT_W-1:0]   wdata_i,
  output chan_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]   ival_o,
  output logic [CNT_W-1:0]   count_o,
  output logic               expire_o
);

  localparam int SYNC_W = (SYNC_TICKS > 1) ? $clog2(SYNC_TICKS) : 1;

  chan_ctrl_t        ctrl_q;
  logic [CNT_W-1:0]  ival_q;
  logic [CNT_W-1:0]  count_q;
  logic              run_q;
  logic              busy_q;
  logic [SYNC_W-1:0] scnt_q;

  logic src_tick, scaled_tick, settle, step, expire;

  mtimer_tick_sel #(
    .NUM_SRC (NUM_SRC),
    .SEL_W   (SEL_W),
    .PSC_W   (PSC_W)
  ) u_tick (
    .clk           (clk),
    .rst           (rst),
    .src_i         (src_i),
    .sel_i         (ctrl_q.src),
    .psc_i         (ctrl_q.psc),
    .clear_i       (settle),
    .run_i         (run_q),
    .src_tick_o    (src_tick),
    .scaled_tick_o (scaled_tick)
  );

  always_comb begin
    settle = busy_q && src_tick && !ctrl_we_i
             && (scnt_q == SYNC_W'(SYNC_TICKS - 1));
    step   = run_q && scaled_tick && !settle;
    expire = step && (count_q == '0);
  end

  // control word: bus write, then settle, then one-shot expiry
  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= chan_ctrl_t'(wdata_i[CTRL_W-1:0]);
    else if (settle) ctrl_q.load <= 1'b0;
    else if (expire && ctrl_q.oneshot) ctrl_q.en <= 1'b0;
  end

  // settling window counted in ticks of the selected source
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      scnt_q <= '0;
    end else if (ctrl_we_i) begin
      busy_q <= 1'b1;
      scnt_q <= '0;
    end else if (busy_q && src_tick) begin
      if (settle) busy_q <= 1'b0;
      else        scnt_q <= scnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else if (settle) run_q <= ctrl_q.en;
    else if (expire && ctrl_q.oneshot) run_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) ival_q <= '0;
    else if (ival_we_i) ival_q <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
    end else if (settle) begin
      if (ctrl_q.load) count_q <= ival_q;
    end else if (step) begin
      if (count_q != '0)        count_q <= count_q - 1'b1;
      else if (!ctrl_q.oneshot) count_q <= ival_q;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign ival_o   = ival_q;
  assign count_o  = count_q;
  assign expire_o = expire;

  // R3: the cycle after a control write never changes the running state
  p_no_early_r3: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we_i && !expire) |=> (run_q == $past(run_q)));

  // R4: load at settle copies the interval and drops the load bit
  p_load_r4: assert property (@(posedge clk) disable iff (rst)
    (settle && ctrl_q.load) |=> (count_q == $past(ival_q) && !ctrl_q.load));

  // R5: one counting tick removes exactly one
  p_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (step && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));

  // R5: a stopped channel keeps its count
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !settle) |=> $stable(count_q));

  // R6: periodic expiry reloads from the interval
  p_periodic_r6: assert property (@(posedge clk) disable iff (rst)
    (expire && !ctrl_q.oneshot) |=> (count_q == $past(ival_q)));

  // R7: one-shot expiry stops at zero
  p_oneshot_r7: assert property (@(posedge clk) disable iff (rst)
    (expire && ctrl_q.oneshot) |=> (!run_q && count_q == '0));

endmodule

// File: rtl/mtimer_periph.sv
module mtimer_periph
  import mtimer_pkg::*;
#(
  parameter int NUM_CH     = 2,
  parameter int NUM_SRC    = 4,
  parameter int CNT_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int SYNC_TICKS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] tick_src_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_we_i,
  input  logic [CNT_W-1:0]   bus_wdata_i,
  output logic [CNT_W-1:0]   bus_rdata_o,
  output logic               irq_o
);

  localparam int BLK_W = ADDR_W - 4;

  logic [BLK_W-1:0]  blk;
  logic [3:0]        word;
  logic [NUM_CH-1:0] ien_q, st_q, expire_v, clr_v;
  logic              wr_shared, wr_ist;
  logic [CNT_W-1:0]  rd_val;

  chan_ctrl_t       ctrl_v [NUM_CH];
  logic [CNT_W-1:0] ival_v [NUM_CH];
  logic [CNT_W-1:0] cnt_v  [NUM_CH];

  assign blk       = bus_addr_i[ADDR_W-1:4];
  assign word      = bus_addr_i[3:0];
  assign wr_shared = bus_we_i && (blk == '0);
  assign wr_ist    = wr_shared && (word == W_SHARED_IST);
  assign clr_v     = wr_ist ? bus_wdata_i[NUM_CH-1:0] : '0;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = bus_we_i && (blk == BLK_W'(g + 1));

    mtimer_chan #(
      .NUM_SRC    (NUM_SRC),
      .CNT_W      (CNT_W),
      .SYNC_TICKS (SYNC_TICKS)
    ) u_chan (
      .clk       (clk),
      .rst       (rst),
      .src_i     (tick_src_i),
      .ctrl_we_i (hit && (word == W_CH_CTRL)),
      .ival_we_i (hit && (word == W_CH_IVAL)),
      .wdata_i   (bus_wdata_i),
      .ctrl_o    (ctrl_v[g]),
      .ival_o    (ival_v[g]),
      .count_o   (cnt_v[g]),
      .expire_o  (expire_v[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else if (wr_shared && word == W_SHARED_IEN) ien_q <= bus_wdata_i[NUM_CH-1:0];
  end

  // expiry wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) st_q <= '0;
    else     st_q <= (st_q & ~clr_v) | expire_v;
  end

  always_comb begin
    rd_val = '0;
    if (blk == '0) begin
      if (word == W_SHARED_IEN)      rd_val[NUM_CH-1:0] = ien_q;
      else if (word == W_SHARED_IST) rd_val[NUM_CH-1:0] = st_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (blk == BLK_W'(i + 1)) begin
        case (word)
          W_CH_CTRL: rd_val = CNT_W'(ctrl_v[i]);
          W_CH_IVAL: rd_val = ival_v[i];
          W_CH_CNT:  rd_val = cnt_v[i];
          default:   rd_val = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      bus_rdata_o <= rd_val;
      irq_o       <= |(st_q & ien_q);
    end
  end

  // R8: every expiry leaves its status bit set
  p_status_set_r8: assert property (@(posedge clk) disable iff (rst)
    (expire_v != '0) |=> ((st_q & $past(expire_v)) == $past(expire_v)));

  // R8: a 1 written to status clears it unless that channel expired
  p_w1c_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_ist && expire_v == '0) |=> ((st_q & $past(bus_wdata_i[NUM_CH-1:0])) == '0));

  // R9: no enabled pending bit, no interrupt
  p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    ((st_q & ien_q) == '0) |=> !irq_o);

endmodule

// File: tb/mtimer_periph_bench.sv
module mtimer_periph_bench;
  localparam int NCH  = 2;
  localparam int NSRC = 4;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  auto_t = '0;
  logic        man_t = 1'b0;
  logic [3:0]  ticks;
  logic [7:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic [15:0] lfsr = 16'hACE1;
  int          cyc = 0;
  int          checks = 0;
  int          fails = 0;
  bit          done = 0;

  always #4 clk = ~clk;
  assign ticks = {man_t, auto_t};

  mtimer_periph u_mtimer_periph (
    .clk(clk), .rst(rst), .tick_src_i(ticks), .bus_addr_i(addr),
    .bus_we_i(we), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference
  logic [7:0]  m_ctrl [NCH];
  logic [31:0] m_ival [NCH];
  logic [31:0] m_cnt  [NCH];
  bit          m_run  [NCH];
  bit          m_busy [NCH];
  int          m_scnt [NCH];
  int          m_pre  [NCH];
  logic [1:0]  m_ien, m_st;
  logic [31:0] m_rdata;
  bit          m_irq;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == 8'h00) v[1:0] = m_ien;
    if (a == 8'h04) v[1:0] = m_st;
    for (int c = 0; c < NCH; c++) begin
      if (a == 8'(16*c + 16)) v = {24'h0, m_ctrl[c]};
      if (a == 8'(16*c + 20)) v = m_ival[c];
      if (a == 8'(16*c + 24)) v = m_cnt[c];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    logic [31:0] rd;
    logic [1:0]  expv, clr;
    logic [7:0]  oc;
    bit src, cw, iw, settle, scaled, step, ex, nirq;
    int div;
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_ctrl[c] = '0; m_ival[c] = '0; m_cnt[c] = '0;
        m_run[c] = 0; m_busy[c] = 0; m_scnt[c] = 0; m_pre[c] = 0;
      end
      m_ien = '0; m_st = '0; m_rdata = '0; m_irq = 0;
    end else begin
      rd   = m_read(addr);
      nirq = |(m_st & m_ien);
      expv = '0;
      for (int c = 0; c < NCH; c++) begin
        oc     = m_ctrl[c];
        src    = ticks[oc[3:2]];
        cw     = we && (addr == 8'(16*c + 16));
        iw     = we && (addr == 8'(16*c + 20));
        settle = m_busy[c] && src && (m_scnt[c] == SYNC - 1) && !cw;
        div    = 1 << oc[6:4];
        scaled = src && ((m_pre[c] % div) == div - 1);
        step   = m_run[c] && scaled && !settle;
        ex     = step && (m_cnt[c] == 0);
        expv[c] = ex;
        if (cw) m_ctrl[c] = wdata[7:0];
        else if (settle) m_ctrl[c][1] = 1'b0;
        else if (ex && oc[7]) m_ctrl[c][0] = 1'b0;
        if (cw) begin m_busy[c] = 1; m_scnt[c] = 0; end
        else if (m_busy[c] && src) begin
          if (settle) m_busy[c] = 0; else m_scnt[c]++;
        end
        if (settle) m_pre[c] = 0;
        else if (m_run[c] && src) m_pre[c] = (m_pre[c] + 1) % 128;
        if (settle) begin
          if (oc[1]) m_cnt[c] = m_ival[c];
        end else if (step) begin
          if (m_cnt[c] != 0) m_cnt[c] = m_cnt[c] - 1;
          else if (!oc[7]) m_cnt[c] = m_ival[c];
        end
        if (settle) m_run[c] = oc[0];
        else if (ex && oc[7]) m_run[c] = 0;
        if (iw) m_ival[c] = wdata;
      end
      clr = (we && addr == 8'h04) ? wdata[1:0] : 2'b00;
      m_st = (m_st & ~clr) | expv;
      if (we && addr == 8'h00) m_ien = wdata[1:0];
      m_rdata = rd;
      m_irq   = nirq;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(rdata == m_rdata, "R1 read data vs model", rdata, m_rdata);
      chk(irq == m_irq, "R9 irq vs model", 32'(irq), 32'(m_irq));
    end
  end

  // free-running sources: 0 always, 1 pseudo-random, 2 every third cycle
  always @(negedge clk) begin
    cyc++;
    lfsr      <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    auto_t[0] <= 1'b1;
    auto_t[1] <= lfsr[0];
    auto_t[2] <= (cyc % 3 == 0);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; we = 1'b1; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; we = 1'b0;
    @(negedge clk);
    v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse3();
    man_t = 1'b1;
    @(negedge clk);
    man_t = 1'b0;
  endtask

  initial begin
    logic [31:0] v, a, b;
    bit seen;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    chk(irq == 1'b0, "R11 irq after reset", 32'(irq), 0);
    rd(8'h10, v); chk(v == 0, "R11 ctrl0 after reset", v, 0);
    rd(8'h18, v); chk(v == 0, "R11 count0 after reset", v, 0);

    // R1 map edges
    rd(8'h0C, v); chk(v == 0, "R1 unmapped 0x0C", v, 0);
    rd(8'h30, v); chk(v == 0, "R1 unmapped 0x30", v, 0);
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, v); chk(v == 32'h3, "R1 enable width", v, 32'h3);

    // R2/R3/R4/R6 periodic on source 0
    wr(8'h14, 32'd5);
    wr(8'h10, 32'h0000_0103);
    rd(8'h10, v); chk(v == 32'h03, "R3 load still pending", v, 32'h03);
    idle(2);
    rd(8'h10, v); chk(v == 32'h01, "R4 load bit self-clears, R2 upper bits dropped", v, 32'h01);
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      @(negedge clk);
      if (irq) seen = 1;
    end
    chk(seen, "R6 periodic expiry raises irq", 32'(seen), 1);
    rd(8'h04, v); chk(v[0] == 1'b1, "R6 status bit 0", v, 32'h1);
    wr(8'h10, 32'h0);
    idle(4);
    wr(8'h04, 32'h3);
    rd(8'h04, v); chk(v == 0, "R8 write-1-to-clear", v, 0);
    chk(irq == 1'b0, "R9 irq drops after clear", 32'(irq), 0);

    // R7/R8/R9 one-shot on channel 1 with interrupts masked
    wr(8'h00, 32'h0);
    wr(8'h24, 32'd3);
    wr(8'h20, 32'h83);
    idle(20);
    rd(8'h04, v); chk(v == 32'h2, "R8 status sets while masked", v, 32'h2);
    chk(irq == 1'b0, "R9 masked irq stays low", 32'(irq), 0);
    rd(8'h20, v); chk(v == 32'h80, "R7 enable self-clears", v, 32'h80);
    rd(8'h28, v); chk(v == 0, "R7 count rests at zero", v, 0);
    wr(8'h00, 32'h2);
    idle(1);
    chk(irq == 1'b1, "R9 irq after unmasking", 32'(irq), 1);
    wr(8'h04, 32'h2);

    // R5 prescale 2^3 on source 0
    wr(8'h24, 32'd100);
    wr(8'h20, 32'h33);
    idle(4);
    rd(8'h28, a);
    idle(15);
    rd(8'h28, b);
    chk(a - b == 2, "R5 prescale 8 over 16 ticks", a - b, 2);

    // R3/R4/R5 settle counted in ticks of source 3
    wr(8'h24, 32'd7);
    wr(8'h20, 32'h0F);
    idle(5);
    rd(8'h20, v); chk(v == 32'h0F, "R3 no settle without ticks", v, 32'h0F);
    pulse3();
    rd(8'h20, v); chk(v == 32'h0F, "R3 one tick is not enough", v, 32'h0F);
    pulse3();
    rd(8'h20, v); chk(v == 32'h0D, "R4 load done on second tick", v, 32'h0D);
    rd(8'h28, v); chk(v == 32'd7, "R4 count loaded", v, 32'd7);
    pulse3(); pulse3(); pulse3();
    rd(8'h28, v); chk(v == 32'd4, "R5 one count per tick", v, 32'd4);
    wr(8'h20, 32'h0C);
    pulse3(); pulse3(); pulse3(); pulse3();
    rd(8'h28, v); chk(v == 32'd3, "R3 old state kept until settle", v, 32'd3);

    // R10 full-range wrap
    wr(8'h14, 32'd1);
    wr(8'h10, 32'h03);
    idle(4);
    wr(8'h14, 32'hFFFF_FFFF);
    idle(6);
    rd(8'h18, v); chk(v >= 32'hFFFF_FF00, "R10 wrap to full range", v, 32'hFFFF_FFF8);

    // mixed sources, compared with the model every cycle
    wr(8'h00, 32'h3);
    wr(8'h14, 32'd9);
    wr(8'h10, 32'h17);
    wr(8'h24, 32'd20);
    wr(8'h20, 32'h0B);
    for (int k = 0; k < 80; k++) begin
      rd(8'h18, v);
      rd(8'h28, v);
      if (k % 10 == 9) wr(8'h04, 32'h3);
    end
    rd(8'h20, v); chk(v == 32'h09, "R2 source 2 periodic control", v, 32'h09);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1-R11 scope actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule